// File: doc/BRIEF.md
# Sixteen-bit Integer ALU with Boolean Compare Results

A purely combinational arithmetic and logic unit for a small sixteen-bit processor. It receives the whole instruction word, from which it takes the 5-bit opcode in bits 4:0 and the immediate fields. It also receives the two source register values and the current value of the destination register. In the same cycle it returns the value to be written back.

Comparisons yield an ordinary register value of zero or one, so no condition flags exist. One load-immediate form replaces only the low byte of the destination and keeps its high byte, which is why the old destination value is an input. Opcodes the unit does not execute, such as memory, branch, jump and system operations, raise an illegal flag and force the result to zero. The flag also rises for register-register forms whose bit 15 is not zero.

Top module: `alu16`

## Requirements
- R1: Opcode 0x00 gives src_a + src_b and opcode 0x01 gives src_a - src_b, both modulo 2^16.
- R2: Opcode 0x02 shifts src_a left by src_b[3:0], filling with zeros; src_b[15:4] is ignored.
- R3: Opcode 0x03 shifts src_a right by src_b[3:0] with zero fill, and opcode 0x04 does the same with copies of src_a[15].
- R4: Opcodes 0x10, 0x11 and 0x12 give the bitwise AND, OR and XOR of src_a and src_b.
- R5: Opcode 0x05 gives src_a plus insn[15:11], read as a signed 5-bit value, modulo 2^16.
- R6: Opcode 0x06 gives insn[15:8] in the high byte and zero in the low byte.
- R7: Opcode 0x07 gives dst_old[15:8] in the high byte and insn[15:8] in the low byte.
- R8: Opcode 0x13 tests src_a == src_b, 0x14 tests signed src_a > src_b, and 0x15 tests signed src_a >= src_b; a true test gives 0x0001 and a false test gives 0x0000.
- R9: Opcodes 0x16 and 0x17 test unsigned greater-than and unsigned greater-or-equal, with the same 0x0001/0x0000 result.
- R10: Opcodes 0x08 to 0x0F and 0x18 to 0x1F set illegal to 1 and result to 0x0000.
- R11: A register-register opcode (0x00 to 0x04, 0x10 to 0x17) with insn[15] = 1 sets illegal to 1 and result to 0x0000. Opcodes 0x05 to 0x07 treat bit 15 as immediate data and keep illegal at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction word: opcode in 4:0, imm5 in 15:11, imm8 in 15:8 |
| src_a | input | 16 | First source register value |
| src_b | input | 16 | Second source register value |
| dst_old | input | 16 | Current destination register value |
| result | output | 16 | Write-back value |
| illegal | output | 1 | Opcode not executed here, or malformed encoding |

## Verification
The sweep crosses every opcode, both values of bit 15, and a set of operand values at the sign and carry boundaries: 0x7FFF against 0x8000, equal operands, and all ones. This catches a comparator that mixes up signed and unsigned order, which shows up as a wrong 0/1 on exactly those pairs. Shift amounts cover 0, 15, and values with src_b[15:4] set. A unit that used too many amount bits returns zero or a sign fill where a real shift was due, and a shift right that fills wrongly differs only when src_a[15] is set. It also checks that a negative imm5 is sign-extended, that the byte-merge load keeps the high byte of dst_old, and that the illegal cases give a zero result. A unit that let bit 15 reach the immediate forms as an error would flag legal immediates.

// File: rtl/alu16.sv
module alu16 (
  input  logic [15:0] insn,
  input  logic [15:0] src_a,
  input  logic [15:0] src_b,
  input  logic [15:0] dst_old,
  output logic [15:0] result,
  output logic        illegal
);
  localparam int W = 16;
  localparam int SHW = $clog2(W);

  localparam logic [4:0] OP_ADD  = 5'h00, OP_SUB  = 5'h01, OP_SLL = 5'h02,
                         OP_SRL  = 5'h03, OP_SRA  = 5'h04, OP_ADDI = 5'h05,
                         OP_LUI  = 5'h06, OP_LLI  = 5'h07, OP_AND = 5'h10,
                         OP_OR   = 5'h11, OP_XOR  = 5'h12, OP_EQ  = 5'h13,
                         OP_GT   = 5'h14, OP_GE   = 5'h15, OP_GTU = 5'h16,
                         OP_GEU  = 5'h17;

  logic [4:0]     opc;
  logic [SHW-1:0] shamt;
  logic [W-1:0]   imm5_x, raw;
  logic           known, rrr_form, malformed;
  logic           lt_s, lt_u, same;

  assign opc    = insn[4:0];
  assign shamt  = src_b[SHW-1:0];
  assign imm5_x = {{(W-5){insn[15]}}, insn[15:11]};
  assign same   = (src_a == src_b);
  assign lt_u   = (src_a < src_b);
  assign lt_s   = ($signed(src_a) < $signed(src_b));

  always_comb begin
    raw      = '0;
    known    = 1'b1;
    rrr_form = 1'b1;
    case (opc)
      OP_ADD:  raw = src_a + src_b;
      OP_SUB:  raw = src_a - src_b;
      OP_SLL:  raw = src_a << shamt;
      OP_SRL:  raw = src_a >> shamt;
      OP_SRA:  raw = W'($signed(src_a) >>> shamt);
      OP_ADDI: begin raw = src_a + imm5_x;           rrr_form = 1'b0; end
      OP_LUI:  begin raw = {insn[15:8], 8'h00};       rrr_form = 1'b0; end
      OP_LLI:  begin raw = {dst_old[15:8], insn[15:8]}; rrr_form = 1'b0; end
      OP_AND:  raw = src_a & src_b;
      OP_OR:   raw = src_a | src_b;
      OP_XOR:  raw = src_a ^ src_b;
      OP_EQ:   raw = W'(same);
      OP_GT:   raw = W'(!lt_s && !same);
      OP_GE:   raw = W'(!lt_s);
      OP_GTU:  raw = W'(!lt_u && !same);
      OP_GEU:  raw = W'(!lt_u);
      default: begin known = 1'b0; rrr_form = 1'b0; end
    endcase
  end

  assign malformed = rrr_form && insn[15];
  assign illegal   = !known || malformed;
  assign result    = illegal ? '0 : raw;
endmodule

module alu16_chk (
  input logic [15:0] insn,
  input logic [15:0] src_a,
  input logic [15:0] src_b,
  input logic [15:0] dst_old,
  input logic [15:0] result,
  input logic        illegal
);
  logic [4:0] op;
  assign op = insn[4:0];

  always_comb begin
    if (!$isunknown({insn, src_a, src_b, dst_old})) begin
      p_zero_when_illegal_r10: assert (!illegal || result == 16'h0000);
      if (op >= 5'h13 && op <= 5'h17 && !insn[15])
        p_bool_result_r8: assert (result[15:1] == 15'h0);
      if (op == 5'h13 && !insn[15] && src_a == src_b)
        p_eq_self_r8: assert (result == 16'h0001);
      if (op == 5'h15 && !insn[15] && src_a == src_b)
        p_ge_equal_r8: assert (result == 16'h0001);
      if (op == 5'h16 && !insn[15] && src_a == src_b)
        p_gtu_equal_r9: assert (result == 16'h0000);
      if (op == 5'h06)
        p_lui_low_zero_r6: assert (result[7:0] == 8'h00 && !illegal);
      if (op == 5'h07)
        p_lli_keeps_high_r7: assert (result[15:8] == dst_old[15:8] && !illegal);
      if (insn[15] && (op <= 5'h04 || (op >= 5'h10 && op <= 5'h17)))
        p_bit15_flags_r11: assert (illegal);
      if (op[3] && !op[4])
        p_mem_range_flagged_r10: assert (illegal);
      if (op == 5'h02 && !insn[15] && src_b[3:0] == 4'd0)
        p_shift_zero_identity_r2: assert (result == src_a);
    end
  end
endmodule

bind alu16 alu16_chk u_chk (.*);

// File: tb/sim_alu16.sv
module sim_alu16;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] insn, src_a, src_b, dst_old, result;
  logic        illegal;
  int checks = 0, failures = 0;
  bit done = 0;

  alu16 u0 (.insn(insn), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
            .result(result), .illegal(illegal));

  function automatic logic [15:0] shr(input logic [15:0] v, input int n, input bit fill);
    logic [15:0] t = v;
    for (int i = 0; i < n; i++) t = {fill & v[15], t[15:1]};
    return t;
  endfunction

  function automatic string req_of(input logic [4:0] op, input bit b15);
    if (op >= 5'h08 && op <= 5'h0F || op >= 5'h18) return "R10";
    if (b15 && (op <= 5'h04 || op >= 5'h10)) return "R11";
    case (op)
      5'h00, 5'h01: return "R1";
      5'h02: return "R2";
      5'h03, 5'h04: return "R3";
      5'h05: return "R5";
      5'h06: return "R6";
      5'h07: return "R7";
      5'h10, 5'h11, 5'h12: return "R4";
      5'h13, 5'h14, 5'h15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [15:0] i, a, b, d, output logic [15:0] r, output logic il);
    int sa, sb, imm, sh;
    logic [4:0] op = i[4:0];
    bit rr = (op <= 5'h04) || (op >= 5'h10 && op <= 5'h17);
    sa = $signed(a); sb = $signed(b);
    imm = i[15:11]; if (imm > 15) imm = imm - 32;
    sh = b % 16;
    il = 0; r = 0;
    if ((op >= 5'h08 && op <= 5'h0F) || op >= 5'h18 || (rr && i[15])) begin il = 1; return; end
    case (op)
      5'h00: r = 16'((a + b) % 65536);
      5'h01: r = 16'((65536 + a - b) % 65536);
      5'h02: r = 16'((a * (32'd1 << sh)) % 65536);
      5'h03: r = shr(a, sh, 0);
      5'h04: r = shr(a, sh, 1);
      5'h05: r = 16'((a + 65536 + imm) % 65536);
      5'h06: r = 16'(i[15:8] * 256);
      5'h07: r = 16'((d / 256) * 256 + i[15:8]);
      5'h10: r = a & b;
      5'h11: r = a | b;
      5'h12: r = a ^ b;
      5'h13: r = (a == b) ? 1 : 0;
      5'h14: r = (sa > sb) ? 1 : 0;
      5'h15: r = (sa >= sb) ? 1 : 0;
      5'h16: r = (int'(a) > int'(b)) ? 1 : 0;
      default: r = (int'(a) >= int'(b)) ? 1 : 0;
    endcase
  endtask

  task automatic apply(input logic [15:0] i, a, b, d);
    logic [15:0] er; logic ei;
    @(negedge clk);
    insn = i; src_a = a; src_b = b; dst_old = d;
    @(posedge clk); #1;
    model(i, a, b, d, er, ei);
    checks++;
    if (result !== er || illegal !== ei) begin
      failures++;
      $display("FAIL %s op=%h insn=%h a=%h b=%h d=%h: got result=%h illegal=%b, expected result=%h illegal=%b",
               req_of(i[4:0], i[15]), i[4:0], i, a, b, d, result, illegal, er, ei);
    end
  endtask

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h000F, 16'h0010, 16'h7FFF,
                             16'h8000, 16'h8001, 16'hFFFF, 16'hFFF0, 16'h1234, 16'hA5C3};

  initial begin
    insn = 0; src_a = 0; src_b = 0; dst_old = 0;
    @(posedge clk); #1;
    checks++;
    if (result !== 16'h0000 || illegal !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle add: got %h/%b expected 0000/0", result, illegal);
    end
    for (int op = 0; op < 32; op++)
      for (int hi = 0; hi < 4; hi++)
        for (int x = 0; x < 12; x++)
          for (int y = 0; y < 12; y++) begin
            logic [15:0] up;
            up = (hi == 0) ? 16'h0000 : (hi == 1) ? 16'hF800 : (hi == 2) ? 16'h7B00 : 16'h8A00;
            apply(up | 16'(op) | 16'(y << 5), vals[x], vals[y], vals[(x + y) % 12]);
          end
    for (int s = 0; s < 16; s++) begin
      apply(16'h0002, 16'h8421, 16'(s) | 16'hFFF0, 16'h0);
      apply(16'h0003, 16'h8421, 16'(s) | 16'h0130, 16'h0);
      apply(16'h0004, 16'h8421, 16'(s) | 16'h4000, 16'h0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule